// File: doc/BRIEF.md
# Exhaustive Combinational Device Sweeper

This block drives a 12-input, 6-output combinational device through every one of its 4096 input combinations and reports each response. A 12-bit serial-in/parallel-out stimulus register feeds the device inputs. A maximal-length LFSR supplies its serial input, so moving to the next pattern costs one shift clock instead of a full reload. The LFSR cannot reach the all-zero state, so the sweep applies that pattern first, before the LFSR sequence begins.

After each new pattern, a programmable settle interval elapses. The six device outputs are then loaded in parallel into a capture register and shifted out serially, most significant bit first, into a receive register. The block then presents an 18-bit record holding the pattern and its response, marked by a single-cycle valid pulse. A start pulse begins a sweep. Busy stays high while the sweep runs, and done rises once the last record has gone out.

Top module: `logic_sweep`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `rec_valid` are 0 and `dut_in` is all zeros.
- R2: Each new pattern is formed by a single left shift of `dut_in`: bits [11:1] of the new pattern equal bits [10:0] of the previous pattern, and the new bit enters at bit 0.
- R3: The first pattern of a sweep is 0x000 and the second is 0x001. After that, each new bit 0 is the XOR of bits 11, 5, 3 and 0 of the previous pattern. Each of the 4096 patterns occurs exactly once per sweep.
- R4: A record carries the applied pattern in `rec_data[17:6]` and the response in `rec_data[5:0]`, with `dut_out[i]` at `rec_data[i]`. `dut_in` still holds that pattern while `rec_valid` is high.
- R5: The effective settle count is `settle_cycles`, or 2 when `settle_cycles` is below 2, and it is latched when a sweep starts. Consecutive `rec_valid` pulses are exactly effective settle + 9 cycles apart. Changing `settle_cycles` during a sweep has no effect.
- R6: `rec_valid` is high for one cycle per record, and a sweep emits exactly 4096 records.
- R7: `busy` rises the cycle after start is accepted and falls with the final record. `done` rises at the same time and stays high, with no further records, until the next start.
- R8: A start pulse while `busy` is high is ignored, and the sweep in progress continues unchanged.
- R9: A start after `done` clears `done`, raises `busy` and repeats the full sweep from pattern 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep, acted on only when idle |
| settle_cycles | input | 8 | Settle interval in clocks, minimum 2 applied |
| dut_in | output | 12 | Parallel stimulus to the device |
| dut_out | input | 6 | Parallel response from the device |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_data | output | 18 | {pattern, response} |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep complete |

## Verification
The shift edge sets a new pattern. The capture load follows the effective settle count later, and six serial shifts and one presentation cycle come after that. Each record is therefore due exactly effective settle + 9 cycles after the previous one. The bench timestamps every `rec_valid` on the falling edge and compares the gap with that figure. It does this for a run whose settle value changes mid-sweep and for a run with a settle value below the minimum. The device model in the bench is registered, so a capture that came too early would return the previous pattern's response and fail the record check.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SHIFT,
    S_SETTLE,
    S_LOAD,
    S_UNLOAD,
    S_EMIT
  } sweep_state_e;
endpackage

// File: rtl/sweep_lfsr.sv
module sweep_lfsr #(
  parameter int          W    = 12,
  parameter logic [W-1:0] TAPS = 12'h829
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] state_o,
  output logic         bit_o
);
  logic [W-1:0] q, q_nxt;

  // zero state escapes to 1 so the all-zero pattern is visited once
  assign bit_o = (q == '0) ? 1'b1 : ^(q & TAPS);

  always_comb begin
    q_nxt = q;
    if (clr)       q_nxt = '0;
    else if (step) q_nxt = {q[W-2:0], bit_o};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign state_o = q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (q != '0 && !clr) |=> (q != '0)); // R3
endmodule

// File: rtl/sweep_sipo.sv
module sweep_sipo #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)        q_nxt = '0;
    else if (shift) q_nxt = {q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_SIPO_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(shift) && !$past(clr)) |-> (q[W-1:1] == $past(q[W-2:0]))); // R2
endmodule

// File: rtl/sweep_piso.sv
module sweep_piso #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] pin,
  output logic         sout
);
  logic [W-1:0] q, q_nxt;

  always_comb begin
    q_nxt = q;
    if (load)       q_nxt = pin;
    else if (shift) q_nxt = {q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign sout = q[W-1];

  AST_PISO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R4
endmodule

// File: rtl/logic_sweep.sv
module logic_sweep
  import sweep_pkg::*;
#(
  parameter int           NI   = 12,
  parameter int           NO   = 6,
  parameter int           SW   = 8,
  parameter logic [NI-1:0] TAPS = 12'h829
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SW-1:0]    settle_cycles,
  output logic [NI-1:0]    dut_in,
  input  logic [NO-1:0]    dut_out,
  output logic             rec_valid,
  output logic [NI+NO-1:0] rec_data,
  output logic             busy,
  output logic             done
);
  localparam int RW = NI + NO;
  localparam int BW = (NO > 1) ? $clog2(NO) : 1;
  localparam logic [SW-1:0] SMIN = SW'(2);

  // reset: asynchronous assert, synchronous release
  logic rs0, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rs0} <= 2'b00;
    else        {rst_q, rs0} <= {rs0, 1'b1};
  end

  sweep_state_e st, st_nxt;
  logic [SW-1:0] settle_lat, settle_lat_nxt, cnt, cnt_nxt, eff_in;
  logic [BW-1:0] bcnt, bcnt_nxt;
  logic [NI-1:0] pcnt, pcnt_nxt;
  logic [NO-1:0] rx, rx_nxt;
  logic          done_nxt;
  logic          go, last, do_shift, do_load, do_unload;
  logic [NI-1:0] lfsr_q;
  logic          lfsr_bit, cap_sout;

  assign go        = start && (st == S_IDLE);
  assign last      = (pcnt == {NI{1'b1}});
  assign eff_in    = (settle_cycles < SMIN) ? SMIN : settle_cycles;
  assign do_shift  = (st == S_SHIFT);
  assign do_load   = (st == S_LOAD);
  assign do_unload = (st == S_UNLOAD);

  sweep_lfsr #(.W(NI), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_q), .clr(go), .step(do_shift),
    .state_o(lfsr_q), .bit_o(lfsr_bit));

  sweep_sipo #(.W(NI)) u_stim (
    .clk(clk), .rst_n(rst_q), .clr(go), .shift(do_shift),
    .sin(lfsr_bit), .q(dut_in));

  sweep_piso #(.W(NO)) u_cap (
    .clk(clk), .rst_n(rst_q), .load(do_load), .shift(do_unload),
    .pin(dut_out), .sout(cap_sout));

  always_comb begin
    st_nxt         = st;
    settle_lat_nxt = settle_lat;
    cnt_nxt        = cnt;
    bcnt_nxt       = bcnt;
    pcnt_nxt       = pcnt;
    rx_nxt         = rx;
    done_nxt       = done;
    unique case (st)
      S_IDLE: if (go) begin
        st_nxt         = S_SETTLE;
        settle_lat_nxt = eff_in;
        cnt_nxt        = eff_in - SW'(1);
        pcnt_nxt       = '0;
        done_nxt       = 1'b0;
      end
      S_SHIFT: begin
        st_nxt  = S_SETTLE;
        cnt_nxt = settle_lat - SW'(1);
      end
      S_SETTLE: begin
        if (cnt == '0) st_nxt = S_LOAD;
        else           cnt_nxt = cnt - SW'(1);
      end
      S_LOAD: begin
        st_nxt   = S_UNLOAD;
        bcnt_nxt = '0;
      end
      S_UNLOAD: begin
        rx_nxt   = {rx[NO-2:0], cap_sout};
        bcnt_nxt = bcnt + BW'(1);
        if (bcnt == BW'(NO - 1)) st_nxt = S_EMIT;
      end
      S_EMIT: begin
        pcnt_nxt = pcnt + NI'(1);
        if (last) begin
          st_nxt   = S_IDLE;
          done_nxt = 1'b1;
        end else begin
          st_nxt = S_SHIFT;
        end
      end
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st         <= S_IDLE;
      settle_lat <= SMIN;
      cnt        <= '0;
      bcnt       <= '0;
      pcnt       <= '0;
      rx         <= '0;
      done       <= 1'b0;
    end else begin
      st         <= st_nxt;
      settle_lat <= settle_lat_nxt;
      cnt        <= cnt_nxt;
      bcnt       <= bcnt_nxt;
      pcnt       <= pcnt_nxt;
      rx         <= rx_nxt;
      done       <= done_nxt;
    end
  end

  assign busy      = (st != S_IDLE);
  assign rec_valid = (st == S_EMIT);
  assign rec_data  = {dut_in, rx};

  // clocks elapsed since the stimulus last changed, for the settle check
  logic [3:0] age;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)                 age <= '0;
    else if (go || do_shift)    age <= '0;
    else if (age != 4'hF)       age <= age + 4'd1;
  end

  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_q)
    do_load |-> (age >= 4'd2)); // R5
  AST_STIM_TRACKS_LFSR: assert property (@(posedge clk) disable iff (!rst_q)
    dut_in == lfsr_q); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    rec_valid |=> !rec_valid); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    !(busy && done)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_q)
    (start && busy && !rec_valid) |=> busy); // R8
endmodule

// File: tb/sim_logic_sweep.sv
module sim_logic_sweep;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  settle_cycles = 8'd5;
  logic [11:0] dut_in;
  logic [5:0]  dut_out;
  logic        rec_valid;
  logic [17:0] rec_data;
  logic        busy, done;

  always #5 clk = ~clk;

  logic_sweep u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .dut_in(dut_in), .dut_out(dut_out), .rec_valid(rec_valid),
    .rec_data(rec_data), .busy(busy), .done(done));

  // behavioural bus decoder with one register of delay, outputs active low
  function automatic logic [5:0] dev_model(input logic [11:0] p);
    logic q, a0, a13, a14, a15, rd, byt, dsn, h2;
    logic [5:0] f;
    a0 = p[0]; a13 = p[1]; a14 = p[2]; a15 = p[3];
    q = p[6] & ~p[4]; rd = p[7]; byt = p[8]; dsn = p[9]; h2 = p[10];
    f[0] = q & ~a15 & ~rd & a13 & a14 & ~dsn;
    f[1] = q & ~a15 & rd & ~a14;
    f[2] = q & ~a15 & rd & a14;
    f[3] = q & a15 & (~byt | a0);
    f[4] = q & a15 & (~byt | ~a0);
    f[5] = q & a15 & h2;
    return ~f;
  endfunction

  logic [5:0] dev_q;
  always @(posedge clk) dev_q <= dev_model(dut_in);
  assign dut_out = dev_q;

  // {pattern, expected response}
  localparam logic [17:0] VEC [11] = '{
    {12'h000, 6'h3F}, {12'h040, 6'h3F}, {12'h0C0, 6'h3D}, {12'h0C4, 6'h3B},
    {12'h046, 6'h3E}, {12'h048, 6'h27}, {12'h549, 6'h17}, {12'h148, 6'h2F},
    {12'h058, 6'h3F}, {12'h026, 6'h3F}, {12'h246, 6'h3F}};

  int n_chk = 0, n_fail = 0;
  int n_rec = 0, n_seen = 0, eff = 5, cyc = 0, last_cyc = 0;
  logic [11:0] prev_p;
  logic        prev_v = 1'b0;
  logic        seen [4096];
  logic [5:0]  resp_tab [4096];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_run();
    n_rec = 0; n_seen = 0;
    for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
  endtask

  // record monitor on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (prev_v && rec_valid) chk(1'b0, "R6 valid longer than one cycle", 1, 0);
    prev_v <= rec_valid;
    if (rec_valid) begin
      logic [11:0] p;
      logic [5:0]  r;
      p = rec_data[17:6];
      r = rec_data[5:0];
      chk(r == dev_model(p), "R4 response", r, dev_model(p));
      chk(dut_in == p, "R4 pattern held", dut_in, p);
      if (n_rec == 0) begin
        chk(p == 12'h000, "R3 first pattern", p, 0);
      end else begin
        logic [11:0] e;
        e = {prev_p[10:0], (prev_p == 12'h000) ? 1'b1
                          : (prev_p[11] ^ prev_p[5] ^ prev_p[3] ^ prev_p[0])};
        chk(p[11:1] == prev_p[10:0], "R2 single shift", p, prev_p);
        chk(p == e, "R3 next pattern", p, e);
        chk(cyc - last_cyc == eff + 9, "R5 record spacing", cyc - last_cyc, eff + 9);
      end
      if (seen[p]) chk(1'b0, "R3 repeated pattern", p, 0);
      else n_seen++;
      seen[p] = 1'b1;
      resp_tab[p] = r;
      prev_p = p;
      last_cyc = cyc;
      n_rec++;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_done(input int max);
    int n = 0;
    while (!done && n < max) begin @(negedge clk); n++; end
    if (!done) begin
      chk(1'b0, "R7 watchdog expired", n, max);
      summary();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && rec_valid == 0, "R1 outputs in reset", {busy, done, rec_valid}, 0);
    chk(dut_in == 12'h000, "R1 stimulus in reset", dut_in, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && rec_valid == 0, "R1 idle after reset", {busy, done, rec_valid}, 0);

    // run 1: settle 5, mid-sweep start and settle change must have no effect
    clear_run(); eff = 5; settle_cycles = 8'd5;
    pulse_start();
    chk(busy == 1, "R7 busy after start", busy, 1);
    repeat (100) @(negedge clk);
    settle_cycles = 8'd0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy == 1, "R8 busy after ignored start", busy, 1);
    wait_done(80000);
    chk(busy == 0, "R7 busy low at done", busy, 0);
    chk(n_rec == 4096, "R6 record count", n_rec, 4096);
    chk(n_seen == 4096, "R3 distinct patterns", n_seen, 4096);
    for (int i = 0; i < 11; i++)
      chk(resp_tab[VEC[i][17:6]] == VEC[i][5:0], "R4 table vector",
          resp_tab[VEC[i][17:6]], VEC[i][5:0]);
    repeat (30) @(negedge clk);
    chk(done == 1 && busy == 0, "R7 done held", {done, busy}, 2);
    chk(n_rec == 4096, "R7 no records after done", n_rec, 4096);

    // run 2: settle below minimum is raised to 2; restart from done
    clear_run(); eff = 2; settle_cycles = 8'd0;
    pulse_start();
    chk(done == 0 && busy == 1, "R9 restart clears done", {done, busy}, 1);
    wait_done(80000);
    chk(n_rec == 4096, "R9 second sweep count", n_rec, 4096);
    chk(n_seen == 4096, "R9 second sweep distinct", n_seen, 4096);
    chk(busy == 0, "R9 idle after second sweep", busy, 0);
    summary();
  end
endmodule